// File: doc/BRIEF.md
# Interprocessor and Interval-Timer Interrupt Controller

This block holds the per-processor interrupt state for a system of up to four CPUs. A single 64-bit control word carries three groups of bits. The first group is an interprocessor-interrupt status bit for each CPU. The second is an interval-timer status bit for each CPU. The third is a pair of arbitration fields, a small read/write field and a fixed revision bit. Each group has its own write rule, so one write can clear some bits, set others and copy still others.

Each CPU also has its own 24-bit ignore counter. On every rising edge of a shared periodic tick, all counters step down together. Once a counter has gone below zero, its overflow flag stays set. From then on, every tick raises that CPU's timer status bit and its timer interrupt line, which lets software skip a chosen number of ticks.

Software reaches the block through a register port. That port carries the index of the requesting CPU, and the index comes back in the two lowest bits when the control word is read. Reads are registered and return one cycle after the request.

Top module: `ipi_tick_ctrl`

## Requirements
- R1: After reset, the control word holds only bit 35 (the revision bit). All counters read 0, and every `ipi_o` and `timer_irq_o` line is low.
- R2: A read of the control word (offset 0x080) returns the stored word with bits 1:0 replaced by `reg_cpu`.
- R3: In a control-word write, a 1 in bit 4+i clears CPU i's timer status bit, and a 1 in bit 8+i clears CPU i's interprocessor status bit. A 0 in these bits leaves them unchanged.
- R4: In a control-word write, a 1 in bit 12+i sets CPU i's interprocessor status bit (bit 8+i), and the set wins over a clear in the same write. Bits 15:12 always read 0. Each `ipi_o[i]` equals status bit 8+i and changes only on a write.
- R5: A control-word write with bit 20 set first clears all of bits 23:16, and only then applies the set rules of R6 and R7.
- R6: Bits 23:20 are write-1-to-set.
- R7: Bits 19:16 take the written ones only when, after R5, the field is zero. Otherwise the write leaves them unchanged.
- R8: Bits 43:40 are loaded from every control-word write. Bits 63:44, 39:36, 34:24 and 3:2 always read 0.
- R9: A write to CPU i's counter stores the low 24 bits of the data and clears the overflow bit (bit 24). The counters for CPUs 0 to 3 sit at offsets 0x380, 0x3C0, 0x700 and 0x740, and a read returns bits 24:0.
- R10: On each rising edge of `tick_in`, every counter steps down by one as a 25-bit value, and bit 24 stays set once it is set. A held-high level or a falling edge causes no step.
- R11: After a step, if bit 24 of CPU i's counter is set, timer status bit 4+i becomes 1. `timer_irq_o[i]` follows that bit and only a control-word write can lower it.
- R12: When a tick sets a timer status bit in the same cycle that a write clears it, the bit ends up set.
- R13: `rd_valid` pulses exactly one cycle after `reg_rd`. Any offset other than the control word and the four counters reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 64 | Write data |
| reg_cpu | input | 2 | Index of the requesting CPU |
| rd_valid | output | 1 | Read data valid, one cycle after `reg_rd` |
| rd_data | output | 64 | Read data |
| tick_in | input | 1 | Shared periodic timer line, synchronous to `clk` |
| ipi_o | output | NCPU | Interprocessor interrupt per CPU |
| timer_irq_o | output | NCPU | Interval-timer interrupt per CPU |

## Verification
The bench targets the arbitration-field ordering: a write with bit 20 set must clear bits 23:16 before re-setting bit 20. If the design applied the clear after the set, it would read back 0 in bit 20, and if it tested the conditional field before the clear, it would keep stale values. The bench also lets a counter step from zero and keeps ticking after it has overflowed. A design that lost the sticky flag would stop raising the timer line, and one that stepped on the held level would run the counters ahead of the expected values. Finally, the bench lands a timer-bit clear on the same cycle as a tick. A design that let the clear win would drop the timer interrupt.

// File: rtl/ipi_tick_pkg.sv
package ipi_tick_pkg;
   localparam int DATA_W    = 64;
   localparam int OFS_W     = 12;
   localparam int ITI_LSB   = 4;
   localparam int IPI_LSB   = 8;
   localparam int REQ_LSB   = 12;
   localparam int ABW_LSB   = 16;
   localparam int ABT_LSB   = 20;
   localparam int ACL_BIT   = 20;
   localparam int FLD_W     = 4;
   localparam int REV_BIT   = 35;
   localparam int RW_LSB    = 40;
   localparam logic [OFS_W-1:0] CTRL_OFS = 12'h080;

   // Offset of a CPU's ignore counter; the split layout is fixed by the map.
   function automatic logic [OFS_W-1:0] cnt_ofs(input int idx);
      case (idx)
         0:       return 12'h380;
         1:       return 12'h3C0;
         2:       return 12'h700;
         default: return 12'h740;
      endcase
   endfunction
endpackage

// File: rtl/ipi_tick_ctrl_word.sv
module ipi_tick_ctrl_word
   import ipi_tick_pkg::*;
#(
   parameter int NCPU = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic [NCPU-1:0]   tmr_set,
   output logic [DATA_W-1:0] word_q,
   output logic [NCPU-1:0]   tmr_q,
   output logic [NCPU-1:0]   ipi_q
);
   logic [NCPU-1:0]  tmr_r, tmr_n, ipi_r, ipi_n;
   logic [FLD_W-1:0] arb_lo_r, arb_lo_n, arb_hi_r, arb_hi_n, rw_r, rw_n;

   always_comb begin
      tmr_n    = tmr_r;
      ipi_n    = ipi_r;
      arb_lo_n = arb_lo_r;
      arb_hi_n = arb_hi_r;
      rw_n     = rw_r;
      if (wr_en) begin
         tmr_n = tmr_r & ~wdata[ITI_LSB +: NCPU];
         ipi_n = (ipi_r & ~wdata[IPI_LSB +: NCPU]) | wdata[REQ_LSB +: NCPU];
         if (wdata[ACL_BIT]) begin
            arb_lo_n = '0;
            arb_hi_n = '0;
         end
         arb_hi_n = arb_hi_n | wdata[ABT_LSB +: FLD_W];
         if (arb_lo_n == '0)
            arb_lo_n = wdata[ABW_LSB +: FLD_W];
         rw_n = wdata[RW_LSB +: FLD_W];
      end
      // a tick that sets the bit wins over a clear in the same cycle
      tmr_n = tmr_n | tmr_set;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tmr_r    <= '0;
         ipi_r    <= '0;
         arb_lo_r <= '0;
         arb_hi_r <= '0;
         rw_r     <= '0;
      end else begin
         tmr_r    <= tmr_n;
         ipi_r    <= ipi_n;
         arb_lo_r <= arb_lo_n;
         arb_hi_r <= arb_hi_n;
         rw_r     <= rw_n;
      end
   end

   always_comb begin
      word_q                    = '0;
      word_q[REV_BIT]           = 1'b1;
      word_q[ITI_LSB +: NCPU]   = tmr_r;
      word_q[IPI_LSB +: NCPU]   = ipi_r;
      word_q[ABW_LSB +: FLD_W]  = arb_lo_r;
      word_q[ABT_LSB +: FLD_W]  = arb_hi_r;
      word_q[RW_LSB +: FLD_W]   = rw_r;
   end

   assign tmr_q = tmr_r;
   assign ipi_q = ipi_r;

   logic unused_wdata;
   assign unused_wdata = ^{wdata[63:44], wdata[39:24], wdata[3:0]};
endmodule

// File: rtl/ipi_tick_ign_cnt.sv
module ipi_tick_ign_cnt #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wdata,
   input  logic             tick,
   output logic [CNT_W:0]   cnt_q,
   output logic             hit
);
   localparam int OVF = CNT_W;

   logic [CNT_W:0] cnt_r, dec, stepped;

   always_comb begin
      dec          = cnt_r - 1'b1;
      stepped      = dec;
      stepped[OVF] = dec[OVF] | cnt_r[OVF];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_r <= '0;
      else if (wr_en)
         cnt_r <= {1'b0, wdata};
      else if (tick)
         cnt_r <= stepped;
   end

   assign hit   = tick & stepped[OVF];
   assign cnt_q = cnt_r;
endmodule

// File: rtl/ipi_tick_rd_port.sv
module ipi_tick_rd_port
   import ipi_tick_pkg::*;
#(
   parameter int NCPU   = 4,
   parameter int CNT_W  = 24,
   parameter int ADDR_W = 12
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       rd_en,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [1:0]                 cpu_idx,
   input  logic [DATA_W-1:0]          word_q,
   input  logic [NCPU*(CNT_W+1)-1:0]  cnt_flat,
   output logic                       rd_valid,
   output logic [DATA_W-1:0]          rd_data
);
   localparam int CW = CNT_W + 1;

   logic [DATA_W-1:0] mux;

   always_comb begin
      mux = '0;
      if (addr == ADDR_W'(CTRL_OFS))
         mux = {word_q[DATA_W-1:2], cpu_idx};
      for (int i = 0; i < NCPU; i++)
         if (addr == ADDR_W'(cnt_ofs(i)))
            mux = DATA_W'(cnt_flat[i*CW +: CW]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en)
            rd_data <= mux;
      end
   end
endmodule

// File: rtl/ipi_tick_ctrl.sv
module ipi_tick_ctrl
   import ipi_tick_pkg::*;
#(
   parameter int NCPU   = 4,
   parameter int CNT_W  = 24,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [1:0]        reg_cpu,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   input  logic              tick_in,
   output logic [NCPU-1:0]   ipi_o,
   output logic [NCPU-1:0]   timer_irq_o
);
   localparam int CW = CNT_W + 1;

   if (NCPU < 1 || NCPU > FLD_W) begin : g_bad_ncpu
      $error("NCPU must lie in 1..4");
   end
   if (CNT_W < 2 || CNT_W > ABW_LSB + 8) begin : g_bad_cntw
      $error("CNT_W out of range");
   end
   if (ADDR_W < OFS_W) begin : g_bad_addrw
      $error("ADDR_W must cover the register map");
   end

   logic                      tick_q, tick_rise, word_wr;
   logic [NCPU-1:0]           cnt_wr, hit;
   logic [NCPU*CW-1:0]        cnt_flat;
   logic [DATA_W-1:0]         word_q;
   logic [NCPU-1:0]           tmr_q, ipi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) tick_q <= 1'b0;
      else        tick_q <= tick_in;
   end
   assign tick_rise = tick_in & ~tick_q;
   assign word_wr   = reg_wr && (reg_addr == ADDR_W'(CTRL_OFS));

   for (genvar g = 0; g < NCPU; g++) begin : g_cpu
      assign cnt_wr[g] = reg_wr && (reg_addr == ADDR_W'(cnt_ofs(g)));
      ipi_tick_ign_cnt #(.CNT_W(CNT_W)) cnt_i (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_en (cnt_wr[g]),
         .wdata (reg_wdata[CNT_W-1:0]),
         .tick  (tick_rise),
         .cnt_q (cnt_flat[g*CW +: CW]),
         .hit   (hit[g])
      );
   end

   ipi_tick_ctrl_word #(.NCPU(NCPU)) word_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (word_wr),
      .wdata   (reg_wdata),
      .tmr_set (hit),
      .word_q  (word_q),
      .tmr_q   (tmr_q),
      .ipi_q   (ipi_q)
   );

   ipi_tick_rd_port #(.NCPU(NCPU), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) rd_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (reg_rd),
      .addr     (reg_addr),
      .cpu_idx  (reg_cpu),
      .word_q   (word_q),
      .cnt_flat (cnt_flat),
      .rd_valid (rd_valid),
      .rd_data  (rd_data)
   );

   assign ipi_o       = ipi_q;
   assign timer_irq_o = tmr_q;
endmodule

// File: rtl/ipi_tick_ctrl_chk.sv
module ipi_tick_ctrl_chk
   import ipi_tick_pkg::*;
#(
   parameter int NCPU   = 4,
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              rd_valid,
   input logic [NCPU-1:0]   ipi_o,
   input logic [NCPU-1:0]   timer_irq_o,
   input logic              tick_rise
);
   // R13
   rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> rd_valid);
   // R13
   rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> !rd_valid);
   // R4
   ipi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> $stable(ipi_o));
   // R11
   tmr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(timer_irq_o & ~$past(timer_irq_o))) |-> $past(tick_rise));
   // R11
   tmr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(~timer_irq_o & $past(timer_irq_o))) |->
         $past(reg_wr && reg_addr == ADDR_W'(CTRL_OFS)));
   // R10
   tick_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_rise |=> !tick_rise);
endmodule

bind ipi_tick_ctrl ipi_tick_ctrl_chk #(.NCPU(NCPU), .ADDR_W(ADDR_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wr      (reg_wr),
   .reg_rd      (reg_rd),
   .reg_addr    (reg_addr),
   .rd_valid    (rd_valid),
   .ipi_o       (ipi_o),
   .timer_irq_o (timer_irq_o),
   .tick_rise   (tick_rise)
);

// File: tb/ipi_tick_ctrl_tb_top.sv
module ipi_tick_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0, tick_in = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [63:0] reg_wdata = '0;
   logic [1:0]  reg_cpu = '0;
   logic        rd_valid;
   logic [63:0] rd_data;
   logic [3:0]  ipi_o, timer_irq_o;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;
   logic [63:0] exp_q[$];
   string       tag_q[$];

   always #10 clk = ~clk;

   ipi_tick_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_cpu(reg_cpu),
      .rd_valid(rd_valid), .rd_data(rd_data), .tick_in(tick_in),
      .ipi_o(ipi_o), .timer_irq_o(timer_irq_o)
   );

   // monitor: pops one expected item per returned read
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         n_cmp++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R13: unexpected read data %h, expected none", rd_data);
         end else begin
            logic [63:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (rd_data !== e) begin
               n_bad++;
               $display("FAIL %s: read %h expected %h", t, rd_data, e);
            end
         end
      end
   end

   task automatic wr(input logic [11:0] a, input logic [63:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [1:0] c,
                     input logic [63:0] e, input string t);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a; reg_cpu = c;
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic chk_out(input string t, input logic [3:0] ipi_e,
                          input logic [3:0] tmr_e);
      n_cmp++;
      if (ipi_o !== ipi_e || timer_irq_o !== tmr_e) begin
         n_bad++;
         $display("FAIL %s: ipi %b timer %b expected ipi %b timer %b",
                  t, ipi_o, timer_irq_o, ipi_e, tmr_e);
      end
   endtask

   // one rising edge, level held a few cycles, then a falling edge
   task automatic tick();
      @(negedge clk);
      tick_in = 1'b1;
      repeat (3) @(negedge clk);
      tick_in = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      @(negedge clk);
      chk_out("R1 reset outputs", 4'b0000, 4'b0000);
      rd(12'h080, 2'd0, 64'h0000_0008_0000_0000, "R1 reset word");
      rd(12'h740, 2'd0, 64'h0, "R1 reset counter 3");
      // R2 cpu index in bits 1:0
      rd(12'h080, 2'd2, 64'h0000_0008_0000_0002, "R2 cpu index");
      // R4 request bits 12 and 14 set status for cpu0 and cpu2
      wr(12'h080, 64'h5000);
      chk_out("R4 ipi request", 4'b0101, 4'b0000);
      rd(12'h080, 2'd0, 64'h0000_0008_0000_0500, "R4 request not stored");
      // R3 clear bit 8
      wr(12'h080, 64'h0100);
      chk_out("R3 ipi clear", 4'b0100, 4'b0000);
      rd(12'h080, 2'd0, 64'h0000_0008_0000_0400, "R3 word after clear");
      // R6 and R7 sets
      wr(12'h080, 64'h00A3_0000);
      rd(12'h080, 2'd0, 64'h0000_0008_00A3_0400, "R6 R7 field set");
      wr(12'h080, 64'h0004_0000);
      rd(12'h080, 2'd0, 64'h0000_0008_00A3_0400, "R7 nonzero field kept");
      // R5 clear then set
      wr(12'h080, 64'h0015_0000);
      rd(12'h080, 2'd0, 64'h0000_0008_0015_0400, "R5 clear before set");
      // R8 read/write field and reserved bits
      wr(12'h080, 64'h8000_0F00_0000_0000);
      rd(12'h080, 2'd0, 64'h0000_0F08_0015_0400, "R8 rw field set");
      wr(12'h080, 64'h0000_0500_0000_0000);
      rd(12'h080, 2'd1, 64'h0000_0508_0015_0401, "R8 rw field rewrite");
      // R9 counters
      wr(12'h380, 64'h3);
      wr(12'h3C0, 64'h0);
      wr(12'h700, 64'h00FF_FFFF);
      wr(12'h740, 64'h0100_0005);
      rd(12'h380, 2'd0, 64'h3, "R9 counter 0");
      rd(12'h700, 2'd0, 64'hFF_FFFF, "R9 counter 2");
      rd(12'h740, 2'd0, 64'h5, "R9 counter 3 masked");
      // R10 R11 first tick: cpu1 steps below zero
      tick();
      chk_out("R11 first overflow", 4'b0100, 4'b0010);
      rd(12'h380, 2'd0, 64'h2, "R10 single step on held level");
      rd(12'h3C0, 2'd0, 64'h1FF_FFFF, "R10 wrap sets overflow");
      rd(12'h080, 2'd0, 64'h0000_0508_0015_0420, "R11 status bit 5");
      tick();
      rd(12'h3C0, 2'd0, 64'h1FF_FFFE, "R10 sticky overflow");
      wr(12'h080, 64'h0000_0500_0000_0020);
      chk_out("R3 timer clear", 4'b0100, 4'b0000);
      tick();
      chk_out("R11 sticky re-raise", 4'b0100, 4'b0010);
      tick();
      chk_out("R11 cpu0 overflow", 4'b0100, 4'b0011);
      // R12 tick and clear in the same cycle
      @(negedge clk);
      tick_in = 1'b1; reg_wr = 1'b1; reg_addr = 12'h080;
      reg_wdata = 64'h0000_0500_0000_0030;
      @(negedge clk);
      reg_wr = 1'b0;
      chk_out("R12 set wins", 4'b0100, 4'b0011);
      repeat (2) @(negedge clk);
      tick_in = 1'b0;
      repeat (2) @(negedge clk);
      rd(12'h380, 2'd0, 64'h1FF_FFFE, "R10 counter 0 after five ticks");
      rd(12'h740, 2'd0, 64'h0, "R10 counter 3 at zero");
      // R9 write clears overflow, R11 line stays until cleared
      wr(12'h380, 64'h7);
      rd(12'h380, 2'd0, 64'h7, "R9 overflow cleared");
      chk_out("R11 line held after counter write", 4'b0100, 4'b0011);
      wr(12'h080, 64'h0000_0500_0000_0010);
      chk_out("R11 cleared by write", 4'b0100, 4'b0010);
      rd(12'h080, 2'd3, 64'h0000_0508_0015_0423, "R2 R8 final word");
      tick();
      chk_out("R11 cpu3 overflow", 4'b0100, 4'b1010);
      rd(12'h380, 2'd0, 64'h6, "R10 step after rewrite");
      rd(12'h740, 2'd0, 64'h1FF_FFFF, "R10 counter 3 wrap");
      // R13 unmapped offsets
      rd(12'h100, 2'd1, 64'h0, "R13 unmapped read");
      rd(12'h088, 2'd1, 64'h0, "R13 unmapped near word");
      repeat (3) @(negedge clk);
      n_cmp++;
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL R13: %0d reads unanswered, expected 0", exp_q.size());
      end
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule